// File: doc/BRIEF.md
# Register-File String Transfer Sequencer

This block moves a run of bytes between a 32-entry, 32-bit register file and a byte-addressed memory port. It works one beat at a time and runs in either direction: a load fills registers from memory, a store writes register contents to memory. A single-cycle start pulse, taken only while the block is idle, supplies the direction, the first address, the first register, the byte count and the mode. Once the last beat has been acknowledged, a one-cycle done pulse ends the transfer.

The block has two modes. In multi-word mode it covers every register from the start register up to the last one, using whole words. In string mode it moves any byte count. Full words go to consecutive registers, and the register index wraps to 0 after the last register. A final 1 to 3 bytes are packed into the top of one more register.

The register file sits outside the block. The block drives the register index and a write strobe, and it reads the indexed entry combinationally. The memory port follows a request/acknowledge protocol and takes word, halfword and byte accesses, with data right-justified on the bus.

Top module: `rf_string_mover`

## Requirements
- R1: In multi-word mode (`multiWord`=1) the block moves whole words for registers startReg through 31 in ascending order, (32 - startReg) × 4 bytes in total, and `byteCount` is not used.
- R2: Memory is big-endian. `memSize` is 2 for a word, 1 for a halfword and 0 for a byte, and it never takes the value 3. Read and write data sit right-justified on `memRdata`/`memWdata`, and the byte at the lowest address is the most significant one. The byte at the first address of a word maps to register bits 31:24.
- R3: In string mode, after each full word the register index increments, and it wraps from 31 back to 0. Consecutive accesses advance the address by the size of the access just done.
- R4: A string request with `byteCount`=0 raises `done` in the cycle after the start pulse. It makes no memory request and no register write.
- R5: On a load tail the block zero-fills the unused bits. With 1 byte left, the byte goes to bits 31:24 and bits 23:0 are zero. With 2 bytes left, a halfword access goes to bits 31:16. With 3 bytes left, a halfword access at address A is followed by a byte access at A+2, and the register becomes {halfword, byte, 8'h00}, written once.
- R6: On a store tail the data comes from the top of the register. One byte is taken from bits 31:24 and two bytes from bits 31:16. Three bytes are sent as a halfword from bits 31:16 at A and then a byte from bits 15:8 at A+2.
- R7: With `addrMode32`=1, each memory address has bits 63:32 at zero. This covers the start address, which is truncated, and every increment, so the address wraps from 0xFFFFFFFF to 0. With `addrMode32`=0 the address carries into bit 32.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the one-cycle `done` pulse. A start pulse seen while `busy` is high, including the done cycle, is ignored.
- R9: `rfWe` is asserted only in a cycle where a load beat completes (`memReq` and `memAck` high). Stores never write registers, and registers the transfer does not cover keep their values.
- R10: Once `memReq` is raised, it stays high until `memAck`, and `memAddr`, `memSize` and `memWe` stay unchanged for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| dirStore | input | 1 | 1 = store registers to memory, 0 = load |
| multiWord | input | 1 | 1 = multi-word mode, 0 = string mode |
| addrMode32 | input | 1 | 1 = addresses wrap at 32 bits |
| startAddr | input | ADDR_W | First byte address |
| startReg | input | 5 | First register index |
| byteCount | input | CNT_W | String-mode byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memSize | output | 2 | 0 byte, 1 halfword, 2 word |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | 32 | Write data, right-justified |
| memAck | input | 1 | Access complete |
| memRdata | input | 32 | Read data, right-justified, valid with memAck |
| rfWe | output | 1 | Register file write strobe |
| rfAddr | output | 5 | Register index for read and write |
| rfWdata | output | 32 | Register write data |
| rfRdata | input | 32 | Register file read data for rfAddr |

## Verification
Two events can land in the same cycle. A new start pulse can coincide with the end of a transfer: the final acknowledge, or the done cycle that follows it. A start can also arrive in the middle of a transfer while a beat is still waiting for its acknowledge. The bench provokes both cases. It raises start in the exact cycle where done is sampled high, and it pulses start with different parameters while a delayed-acknowledge load is in flight. The result is judged at the ports. No further memory request and no second done may appear, no store access may be logged, and the register image and access count must match the original request alone.

// File: rtl/strx_pkg.sv
package strx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch a new request
    logic step;     // current beat acknowledged
  } ctrlStrobe_t;
endpackage

// File: rtl/strx_ctrl.sv
module strx_ctrl
  import strx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        zeroLen,
  input  logic        lastBeat,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
  state_e state, stateNext;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.step    = (state == ST_RUN) && memAck;
    stateNext      = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = zeroLen ? ST_FIN : ST_RUN;
      ST_RUN:  if (memAck && lastBeat) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_RUN);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
endmodule

// File: rtl/strx_dp.sv
module strx_dp
  import strx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 8,
  parameter int REG_N  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic                     dirStore,
  input  logic                     multiWord,
  input  logic                     addrMode32,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic [$clog2(REG_N)-1:0] startReg,
  input  logic [CNT_W-1:0]         byteCount,
  input  logic [31:0]              memRdata,
  input  logic [31:0]              rfRdata,
  output logic                     zeroLen,
  output logic                     lastBeat,
  output logic                     memWe,
  output logic [1:0]               memSize,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [31:0]              memWdata,
  output logic                     rfWe,
  output logic [$clog2(REG_N)-1:0] rfAddr,
  output logic [31:0]              rfWdata
);
  localparam int RIDX_W = $clog2(REG_N);
  localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-32){1'b0}}, {32{1'b1}}};
  localparam logic [RIDX_W-1:0] LAST_REG = RIDX_W'(REG_N - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [RIDX_W-1:0] regQ;
  logic [CNT_W-1:0]  remQ;
  logic              storeQ, m32Q, phaseQ;
  logic [15:0]       accQ;

  accSize_e          sizeNow;
  logic [CNT_W-1:0]  nBytes, multiCnt, regSpan;
  logic              tailSplit;

  function automatic logic [ADDR_W-1:0] wrapAddr(input logic [ADDR_W-1:0] a, input logic m32);
    return m32 ? (a & LOW_MASK) : a;
  endfunction

  always_comb begin
    regSpan  = CNT_W'(REG_N) - CNT_W'(startReg);
    multiCnt = regSpan << 2;
    zeroLen  = !multiWord && (byteCount == '0);

    if (remQ >= CNT_W'(4)) begin
      sizeNow = SZ_WORD; nBytes = CNT_W'(4);
    end else if (remQ >= CNT_W'(2)) begin
      sizeNow = SZ_HALF; nBytes = CNT_W'(2);
    end else begin
      sizeNow = SZ_BYTE; nBytes = CNT_W'(1);
    end
    lastBeat  = (remQ == nBytes);
    tailSplit = (sizeNow == SZ_HALF) && (remQ == CNT_W'(3));

    unique case (sizeNow)
      SZ_WORD: memWdata = rfRdata;
      SZ_HALF: memWdata = {16'h0, rfRdata[31:16]};
      default: memWdata = {24'h0, (phaseQ ? rfRdata[15:8] : rfRdata[31:24])};
    endcase

    unique case (sizeNow)
      SZ_WORD: rfWdata = memRdata;
      SZ_HALF: rfWdata = {memRdata[15:0], 16'h0};
      default: rfWdata = phaseQ ? {accQ, memRdata[7:0], 8'h0} : {memRdata[7:0], 24'h0};
    endcase
  end

  assign memWe   = storeQ;
  assign memSize = sizeNow;
  assign memAddr = addrQ;
  assign rfAddr  = regQ;
  assign rfWe    = strobe.step && !storeQ && !tailSplit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; regQ <= '0; remQ <= '0;
      storeQ <= 1'b0; m32Q <= 1'b0; phaseQ <= 1'b0; accQ <= '0;
    end else if (strobe.capture) begin
      addrQ  <= wrapAddr(startAddr, addrMode32);
      regQ   <= startReg;
      remQ   <= multiWord ? multiCnt : byteCount;
      storeQ <= dirStore;
      m32Q   <= addrMode32;
      phaseQ <= 1'b0;
    end else if (strobe.step) begin
      addrQ  <= wrapAddr(addrQ + ADDR_W'(nBytes), m32Q);
      remQ   <= remQ - nBytes;
      phaseQ <= tailSplit;
      if (tailSplit) accQ <= memRdata[15:0];
      if (sizeNow == SZ_WORD) regQ <= (regQ == LAST_REG) ? '0 : regQ + 1'b1;
    end
  end
endmodule

// File: rtl/rf_string_mover.sv
module rf_string_mover
  import strx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirStore,
  input  logic              multiWord,
  input  logic              addrMode32,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [4:0]        startReg,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              rfWe,
  output logic [4:0]        rfAddr,
  output logic [31:0]       rfWdata,
  input  logic [31:0]       rfRdata
);
  ctrlStrobe_t strobe;
  logic        zeroLen, lastBeat;

  strx_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .start(start), .zeroLen(zeroLen),
    .lastBeat(lastBeat), .memAck(memAck), .strobe(strobe),
    .memReq(memReq), .busy(busy), .done(done)
  );

  strx_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_N(32)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dirStore(dirStore),
    .multiWord(multiWord), .addrMode32(addrMode32), .startAddr(startAddr),
    .startReg(startReg), .byteCount(byteCount), .memRdata(memRdata),
    .rfRdata(rfRdata), .zeroLen(zeroLen), .lastBeat(lastBeat),
    .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
    .memWdata(memWdata), .rfWe(rfWe), .rfAddr(rfAddr), .rfWdata(rfWdata)
  );
endmodule

// File: rtl/rf_string_mover_chk.sv
module rf_string_mover_chk #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              multiWord,
  input logic              addrMode32,
  input logic [CNT_W-1:0]  byteCount,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic [1:0]        memSize,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              rfWe
);
  logic modeQ;
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else if (start && !busy) modeQ <= addrMode32;
  end

  // R9
  rf_write_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (memReq && memAck && !memWe));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memSize) && $stable(memWe)));
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (busy && !done));
  // R2
  size_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memSize != 2'd3));
  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !multiWord && byteCount == '0) |=> (done && !memReq));
  // R7
  wrap32_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && modeQ) |-> (memAddr[ADDR_W-1:32] == '0));
endmodule

bind rf_string_mover rf_string_mover_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chkI (
  .clk(clk), .rstN(rstN), .start(start), .multiWord(multiWord),
  .addrMode32(addrMode32), .byteCount(byteCount), .busy(busy), .done(done),
  .memReq(memReq), .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
  .memAck(memAck), .rfWe(rfWe)
);

// File: tb/rf_string_mover_test.sv
module rf_string_mover_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, dirStore = 1'b0, multiWord = 1'b0, addrMode32 = 1'b0;
  logic [63:0] startAddr = '0;
  logic [4:0]  startReg = '0;
  logic [7:0]  byteCount = '0;
  logic busy, done, memReq, memWe, rfWe;
  logic [1:0]  memSize;
  logic [63:0] memAddr;
  logic [31:0] memWdata, rfWdata, rfRdata;
  logic [4:0]  rfAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  logic [31:0] rf [32];
  logic [31:0] expRf [32];
  logic [7:0]  mem [256];
  logic [7:0]  expMem [256];
  logic [63:0] logAddr [64];
  logic [1:0]  logSize [64];
  int accCount = 0, wrCount = 0, storeSeen = 0, waitCnt = 0, ackDelay = 0;
  int nCmp = 0, nFail = 0;

  always #2 clk = ~clk;

  rf_string_mover uut (
    .clk(clk), .rstN(rstN), .start(start), .dirStore(dirStore),
    .multiWord(multiWord), .addrMode32(addrMode32), .startAddr(startAddr),
    .startReg(startReg), .byteCount(byteCount), .busy(busy), .done(done),
    .memReq(memReq), .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfWdata(rfWdata), .rfRdata(rfRdata)
  );

  assign rfRdata = rf[rfAddr];
  always @(posedge clk) if (rfWe) begin rf[rfAddr] <= rfWdata; wrCount++; end

  // memory model: big-endian, right-justified data, ack after ackDelay cycles
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; waitCnt = 0;
    end else if (memReq && !memAck && waitCnt >= ackDelay) begin
      logic [7:0] a;
      a = memAddr[7:0];
      if (accCount < 64) begin logAddr[accCount] = memAddr; logSize[accCount] = memSize; end
      accCount++;
      if (memWe) begin
        storeSeen++;
        case (memSize)
          2'd2: begin mem[a] = memWdata[31:24]; mem[a+8'd1] = memWdata[23:16];
                      mem[a+8'd2] = memWdata[15:8]; mem[a+8'd3] = memWdata[7:0]; end
          2'd1: begin mem[a] = memWdata[15:8]; mem[a+8'd1] = memWdata[7:0]; end
          default: mem[a] = memWdata[7:0];
        endcase
      end else begin
        case (memSize)
          2'd2: memRdata <= {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
          2'd1: memRdata <= {16'h0, mem[a], mem[a+8'd1]};
          default: memRdata <= {24'h0, mem[a]};
        endcase
      end
      memAck <= 1'b1; waitCnt = 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) waitCnt++;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic seed(input int salt);
    for (int i = 0; i < 32; i++) rf[i] = 32'hC0DE_0000 + i * 32'h0001_0111 + salt;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + salt * 13 + 1);
  endtask

  task automatic expectLoad(input logic [4:0] s, input logic [63:0] a, input int n);
    for (int i = 0; i < 32; i++) expRf[i] = rf[i];
    for (int k = 0; k < (n + 3) / 4; k++) begin
      logic [31:0] v;
      v = '0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < n) v[31 - 8 * j -: 8] = mem[8'(a[7:0] + 8'(4 * k + j))];
      expRf[5'(s + 5'(k))] = v;
    end
  endtask

  task automatic expectStore(input logic [4:0] s, input logic [63:0] a, input int n);
    for (int i = 0; i < 256; i++) expMem[i] = mem[i];
    for (int i = 0; i < n; i++)
      expMem[8'(a[7:0] + 8'(i))] = rf[5'(s + 5'(i / 4))][31 - 8 * (i % 4) -: 8];
  endtask

  task automatic runXfer(input logic st, input logic mw, input logic m32,
                         input logic [63:0] a, input logic [4:0] s, input logic [7:0] n);
    accCount = 0; wrCount = 0; storeSeen = 0;
    @(negedge clk);
    start = 1'b1; dirStore = st; multiWord = mw; addrMode32 = m32;
    startAddr = a; startReg = s; byteCount = n;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    if (!done) check("R8", "transfer timeout", 0, 1);
  endtask

  function automatic int accExpect(input int n);
    return n / 4 + ((n % 4 == 3) ? 2 : ((n % 4 != 0) ? 1 : 0));
  endfunction

  task automatic cmpRf(input string req);
    for (int i = 0; i < 32; i++) check(req, $sformatf("rf[%0d]", i), rf[i], expRf[i]);
  endtask

  task automatic cmpMem(input string req);
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) check(req, $sformatf("mem[%0d]", i), mem[i], expMem[i]);
    check(req, "memory image", 0, 0);
  endtask

  task automatic testReset();
    check("R8", "busy after reset", busy, 0);
    check("R8", "done after reset", done, 0);
    check("R10", "memReq after reset", memReq, 0);
    check("R9", "rfWe after reset", rfWe, 0);
  endtask

  task automatic testMultiLoad();
    seed(1); ackDelay = 0;
    expectLoad(5'd28, 64'h10, 16);
    runXfer(1'b0, 1'b1, 1'b0, 64'h10, 5'd28, 8'd3);
    cmpRf("R1");
    check("R1", "multi access count", accCount, 4);
    for (int i = 0; i < 4; i++) begin
      check("R1", "multi word addr", logAddr[i], 64'h10 + 64'(4 * i));
      check("R2", "word size code", logSize[i], 2'd2);
    end
    check("R2", "first byte in bits 31:24", rf[28][31:24], mem[8'h10]);
  endtask

  task automatic testMultiStore();
    seed(2); ackDelay = 1;
    expectStore(5'd30, 64'h40, 8);
    runXfer(1'b1, 1'b1, 1'b0, 64'h40, 5'd30, 8'd0);
    cmpMem("R1");
    check("R1", "multi store access count", accCount, 2);
    check("R9", "store made no rf write", wrCount, 0);
  endtask

  task automatic testStringLoad(input logic [4:0] s, input logic [63:0] a, input int n, input int dly);
    seed(3 + n); ackDelay = dly;
    expectLoad(s, a, n);
    runXfer(1'b0, 1'b0, 1'b0, a, s, 8'(n));
    cmpRf(n % 4 == 0 ? "R3" : "R5");
    check("R3", "string load access count", accCount, accExpect(n));
    check("R9", "rf writes per register", wrCount, (n + 3) / 4);
    if (n % 4 == 3) begin
      check("R5", "3-tail half addr", logAddr[accCount - 2], a + 64'(n - 3));
      check("R5", "3-tail byte addr", logAddr[accCount - 1], a + 64'(n - 1));
      check("R5", "3-tail sizes", {logSize[accCount - 2], logSize[accCount - 1]}, 4'b0100);
    end
  endtask

  task automatic testStringStore(input logic [4:0] s, input logic [63:0] a, input int n);
    seed(20 + n); ackDelay = 2;
    expectStore(s, a, n);
    runXfer(1'b1, 1'b0, 1'b0, a, s, 8'(n));
    cmpMem("R6");
    check("R6", "string store access count", accCount, accExpect(n));
    check("R9", "store made no rf write", wrCount, 0);
  endtask

  task automatic testZero();
    seed(5); ackDelay = 0;
    for (int i = 0; i < 32; i++) expRf[i] = rf[i];
    accCount = 0; wrCount = 0;
    @(negedge clk);
    start = 1'b1; dirStore = 1'b0; multiWord = 1'b0; byteCount = 8'd0; startReg = 5'd4;
    @(negedge clk);
    start = 1'b0;
    check("R4", "done one cycle after start", done, 1);
    check("R8", "busy during zero-length done", busy, 1);
    @(negedge clk);
    check("R8", "busy falls after done", busy, 0);
    check("R4", "no memory access", accCount, 0);
    check("R4", "no register write", wrCount, 0);
    cmpRf("R4");
  endtask

  task automatic testWrap();
    seed(6); ackDelay = 0;
    runXfer(1'b0, 1'b0, 1'b1, 64'hABCD_0000_FFFF_FFFE, 5'd8, 8'd9);
    check("R7", "truncated start addr", logAddr[0], 64'h0000_0000_FFFF_FFFE);
    check("R7", "32-bit wrap addr", logAddr[1], 64'h2);
    check("R7", "32-bit wrap addr 2", logAddr[2], 64'h6);
    runXfer(1'b0, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFE, 5'd8, 8'd9);
    check("R7", "64-bit carry addr", logAddr[1], 64'h1_0000_0002);
    check("R3", "byte tail addr", logAddr[2], 64'h1_0000_0006);
  endtask

  task automatic testBusyIgnore();
    seed(7); ackDelay = 2;
    expectLoad(5'd29, 64'h80, 12);
    accCount = 0; wrCount = 0; storeSeen = 0;
    @(negedge clk);
    start = 1'b1; dirStore = 1'b0; multiWord = 1'b1; addrMode32 = 1'b0;
    startAddr = 64'h80; startReg = 5'd29;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after accepted start", busy, 1);
    @(negedge clk); @(negedge clk);
    start = 1'b1; dirStore = 1'b1; multiWord = 1'b0; startAddr = 64'h20; startReg = 5'd0; byteCount = 8'd40;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    check("R8", "done reached", done, 1);
    cmpRf("R8");
    check("R8", "mid-transfer start ignored: access count", accCount, 3);
    check("R8", "mid-transfer start ignored: no store", storeSeen, 0);
  endtask

  task automatic testStartAtDone();
    int extraReq, extraDone;
    seed(8); ackDelay = 0;
    runXfer(1'b0, 1'b0, 1'b0, 64'h30, 5'd5, 8'd4);
    // now in done cycle: raise start here
    start = 1'b1; dirStore = 1'b1; multiWord = 1'b0; startAddr = 64'h50; byteCount = 8'd8;
    @(negedge clk);
    start = 1'b0;
    extraReq = 0; extraDone = 0;
    for (int i = 0; i < 10; i++) begin
      if (memReq) extraReq++;
      if (done) extraDone++;
      if (busy) extraDone++;
      @(negedge clk);
    end
    check("R8", "start in done cycle: no request", extraReq, 0);
    check("R8", "start in done cycle: stays idle", extraDone, 0);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  end

  initial begin
    seed(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMultiLoad();
    testMultiStore();
    testStringLoad(5'd31, 64'h08, 7, 0);
    testStringLoad(5'd2,  64'h61, 5, 1);
    testStringLoad(5'd10, 64'hC3, 6, 0);
    testStringLoad(5'd30, 64'h00, 12, 1);
    testStringStore(5'd31, 64'h90, 7);
    testStringStore(5'd3,  64'hA1, 5);
    testStringStore(5'd12, 64'hB2, 6);
    testZero();
    testWrap();
    testBusyIgnore();
    testStartAtDone();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  end
endmodule